// File: doc/BRIEF.md
# Configuration Retry Status Controller

This block keeps, for an endpoint with many functions, one retry-enable flag per physical function in each of 32 slots of 32 functions. A single 32-bit control register, written by the application, picks a slot, a group of eight functions and an 8-bit value for that group. Setting the register's trigger bit starts a fixed-length update. The block clears the trigger itself once the update is done.

For every incoming configuration request the block decides whether to answer with a retry status or with a normal completion. The request carries a slot, a function number and a virtual-function flag with a parent function number. A virtual function is judged by its parent's flag. Each function also keeps a sticky record of having given a normal answer. Once that record is set, the function never asks for a retry again until reset. Software can use this to hold off enumeration until the application is ready.

Top module: `crs_ctrl_top`

## Requirements
- R1: After reset the register reads 0x0000_0000, every enable flag and every sticky record is clear, and `rsp_valid` is low.
- R2: Register bits 7:6, 15:10 and 31:24 always read zero, and values written to them are dropped.
- R3: The register fields are as follows. Bit 0 is the trigger, bits 5:1 are the slot and bits 9:8 are the group index. Bits 23:16 are the group value. An accepted write stores all writable bits, and the stored value reads back.
- R4: An accepted write with bit 0 set starts an update. The field values are latched on the next edge. The flags are written on the second edge after the write. Bit 0 reads 0 after the third edge.
- R5: Any write presented while bit 0 reads 1 is dropped entirely. The register is unchanged and no extra update starts.
- R6: Group index g covers functions 8g+7..8g of the selected slot. Bit k of the group value becomes the enable of function 8g+k. Flags outside that group and slot keep their values.
- R7: A request strobe gives `rsp_valid` high on the next cycle. `rsp_retry` is high only when the target's enable is set and its sticky record is clear, judged on the flags before that edge.
- R8: A request answered without retry sets the target's sticky record. Only reset clears it, and after that the function's enable no longer produces retries.
- R9: When `req_is_vf` is 1, the decision and the sticky record use `req_parent_func` in place of `req_func`.
- R10: An accepted write with bit 0 clear updates the stored fields but does not change any enable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Register write value |
| reg_rd_data | output | 32 | Current register contents |
| req_valid | input | 1 | Configuration request strobe |
| req_slot | input | 5 | Slot of the request |
| req_func | input | 5 | Function number of the request |
| req_is_vf | input | 1 | Request targets a virtual function |
| req_parent_func | input | 5 | Parent physical function of a virtual function |
| rsp_valid | output | 1 | Decision valid, one cycle after the request |
| rsp_retry | output | 1 | 1 = answer with retry status, 0 = normal completion |

## Verification
Two situations are hard to reach from the ports. The first is a request that arrives on the exact edge where an update writes its group. The second is a function whose enable is switched back on after it has already answered normally. The stimulus reaches the first by sending a request on every cycle of an update, together with a dropped write in mid-update. It reaches the second with a sequence of three updates to one group: enable, disable, then enable again, with requests between the updates. A long randomized phase then mixes triggers, plain writes and requests (including virtual ones) against the behavioural model.

// File: rtl/crs_pkg.sv
// Package: constants and the update command shared by the controller.
// Assumes the 32-bit register format with fixed field positions.
package crs_pkg;
    localparam int NUM_SLOTS  = 32;
    localparam int NUM_FUNCS  = 32;
    localparam int GROUP_SIZE = 8;
    localparam int SLOT_W     = $clog2(NUM_SLOTS);
    localparam int FUNC_W     = $clog2(NUM_FUNCS);
    localparam int GRP_W      = $clog2(NUM_FUNCS / GROUP_SIZE);
    localparam int REG_W      = 32;

    // Field positions: other logic decodes these
    localparam int TRIG_BIT = 0;
    localparam int SLOT_LSB = 1;
    localparam int GRP_LSB  = 8;
    localparam int VAL_LSB  = 16;
    localparam logic [REG_W-1:0] WR_MASK = 32'h00FF_033F;

    typedef struct packed {
        logic [SLOT_W-1:0]     slot;
        logic [GRP_W-1:0]      grp;
        logic [GROUP_SIZE-1:0] val;
    } upd_cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_APPLY  = 2'd1,
        ST_FINISH = 2'd2
    } upd_state_t;
endpackage

// File: rtl/crs_cfg_reg.sv
// Control register with a self-clearing trigger and the update sequencer.
// Assumes writes arrive as single-cycle strobes. A write is dropped while
// the trigger reads 1. An update takes a latch cycle and then a write
// cycle, and the trigger clears on the cycle after that.
module crs_cfg_reg
    import crs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             upd_en,
    output upd_cmd_t         upd_cmd
);
    logic [REG_W-1:0] reg_q;
    upd_state_t       state_q;
    upd_cmd_t         cmd_q;

    // Register storage, the sequencer state and the latched command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q   <= '0;
            state_q <= ST_IDLE;
            cmd_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (reg_q[TRIG_BIT]) begin
                        cmd_q.slot <= reg_q[SLOT_LSB +: SLOT_W];
                        cmd_q.grp  <= reg_q[GRP_LSB +: GRP_W];
                        cmd_q.val  <= reg_q[VAL_LSB +: GROUP_SIZE];
                        state_q    <= ST_APPLY;
                    end else if (wr_en) begin
                        reg_q <= wr_data & WR_MASK;
                    end
                end
                ST_APPLY:  state_q <= ST_FINISH;
                ST_FINISH: begin
                    reg_q[TRIG_BIT] <= 1'b0;
                    state_q         <= ST_IDLE;
                end
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    assign rd_data = reg_q;
    assign upd_en  = (state_q == ST_APPLY);
    assign upd_cmd = cmd_q;

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~WR_MASK) == '0);
    assert_busy_holds_trigger_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> rd_data[TRIG_BIT]);
    assert_drop_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_data[TRIG_BIT] && state_q != ST_FINISH) |=> $stable(rd_data));
    assert_single_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> !upd_en);
    assert_trigger_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> ##2 !rd_data[TRIG_BIT]);
endmodule

// File: rtl/crs_flag_bank.sv
// Enable flags and sticky "normal answer given" records per slot and
// function, plus the registered retry decision. Assumes at most one
// group write and one request per cycle. A request sees the flags
// as they were before the edge.
module crs_flag_bank
    import crs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  upd_cmd_t          upd_cmd,
    input  logic              req_valid,
    input  logic [SLOT_W-1:0] req_slot,
    input  logic [FUNC_W-1:0] req_func,
    input  logic              req_is_vf,
    input  logic [FUNC_W-1:0] req_parent_func,
    output logic              rsp_valid,
    output logic              rsp_retry
);
    localparam int GRP_SHIFT = $clog2(GROUP_SIZE);

    logic [NUM_SLOTS-1:0][NUM_FUNCS-1:0] en_q;
    logic [NUM_SLOTS-1:0][NUM_FUNCS-1:0] done_q;
    logic [FUNC_W-1:0]    grp_base;
    logic [NUM_FUNCS-1:0] grp_mask;
    logic [NUM_FUNCS-1:0] grp_data;
    logic [FUNC_W-1:0]    tgt_func;
    logic                 want_retry;

    // Place the 8-bit group value at the group's function positions
    always_comb begin
        grp_base = FUNC_W'(upd_cmd.grp) << GRP_SHIFT;
        grp_mask = NUM_FUNCS'({GROUP_SIZE{1'b1}}) << grp_base;
        grp_data = NUM_FUNCS'(upd_cmd.val) << grp_base;
    end

    // Virtual functions use the parent's flags
    always_comb begin
        tgt_func   = req_is_vf ? req_parent_func : req_func;
        want_retry = en_q[req_slot][tgt_func] && !done_q[req_slot][tgt_func];
    end

    // Flag writes, sticky records and the registered decision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q      <= '0;
            done_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_retry <= 1'b0;
        end else begin
            if (upd_en) begin
                en_q[upd_cmd.slot] <= (en_q[upd_cmd.slot] & ~grp_mask) | grp_data;
            end
            rsp_valid <= req_valid;
            rsp_retry <= req_valid && want_retry;
            if (req_valid && !want_retry) begin
                done_q[req_slot][tgt_func] <= 1'b1;
            end
        end
    end

    assert_rsp_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_spurious_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_retry_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_retry |-> rsp_valid);
    assert_sticky_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((done_q & $past(done_q)) == $past(done_q)));
endmodule

// File: rtl/crs_ctrl_top.sv
// Configuration retry status controller: the control register and
// sequencer feed the flag bank, which answers configuration requests.
// Assumes a single clock domain and a synchronous active-low reset.
module crs_ctrl_top
    import crs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [31:0] reg_wr_data,
    output logic [31:0] reg_rd_data,
    input  logic        req_valid,
    input  logic [4:0]  req_slot,
    input  logic [4:0]  req_func,
    input  logic        req_is_vf,
    input  logic [4:0]  req_parent_func,
    output logic        rsp_valid,
    output logic        rsp_retry
);
    logic     upd_en;
    upd_cmd_t upd_cmd;

    crs_cfg_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .rd_data (reg_rd_data),
        .upd_en  (upd_en),
        .upd_cmd (upd_cmd)
    );

    crs_flag_bank u_bank (
        .clk             (clk),
        .rst_n           (rst_n),
        .upd_en          (upd_en),
        .upd_cmd         (upd_cmd),
        .req_valid       (req_valid),
        .req_slot        (req_slot),
        .req_func        (req_func),
        .req_is_vf       (req_is_vf),
        .req_parent_func (req_parent_func),
        .rsp_valid       (rsp_valid),
        .rsp_retry       (rsp_retry)
    );
endmodule

// File: tb/crs_ctrl_top_test.sv
// Bench: a behavioural reference model updated on each rising edge and
// compared with the outputs on every falling edge.
module crs_ctrl_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        req_valid = 1'b0;
    logic [4:0]  req_slot = '0;
    logic [4:0]  req_func = '0;
    logic        req_is_vf = 1'b0;
    logic [4:0]  req_parent_func = '0;
    logic        rsp_valid;
    logic        rsp_retry;

    always #4 clk = ~clk;  // 125 MHz

    crs_ctrl_top uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .req_valid(req_valid), .req_slot(req_slot),
        .req_func(req_func), .req_is_vf(req_is_vf), .req_parent_func(req_parent_func),
        .rsp_valid(rsp_valid), .rsp_retry(rsp_retry)
    );

    // Reference model state
    bit          m_en   [32][32];
    bit          m_done [32][32];
    logic [31:0] m_reg;
    int          m_age;
    bit          m_rv, m_rr;
    bit          started = 0;
    int          vectors = 0;
    int          miscompares = 0;
    int          cycles = 0;
    string       tag = "R1";

    // Model: decision on the old flags (R7, R9), sticky (R8), register (R2 R3 R5 R10),
    // update timing (R4) and group mapping (R6)
    always @(posedge clk) begin
        int eff;
        if (!rst_n) begin
            foreach (m_en[s, f]) begin m_en[s][f] = 0; m_done[s][f] = 0; end
            m_reg = '0; m_age = 0; m_rv = 0; m_rr = 0;
            started = 1;
        end else begin
            eff  = req_is_vf ? int'(req_parent_func) : int'(req_func);
            m_rv = req_valid;
            m_rr = req_valid && m_en[req_slot][eff] && !m_done[req_slot][eff];
            if (req_valid && !m_rr) m_done[req_slot][eff] = 1;
            if (m_reg[0]) begin
                m_age++;
                if (m_age == 2)
                    for (int k = 0; k < 8; k++)
                        m_en[m_reg[5:1]][int'(m_reg[9:8]) * 8 + k] = m_reg[16 + k];
                if (m_age == 3) begin m_reg[0] = 1'b0; m_age = 0; end
            end else if (reg_wr_en) begin
                m_reg = reg_wr_data & 32'h00FF_033F;
            end
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (started) begin
            vectors++;
            if (reg_rd_data !== m_reg) begin
                miscompares++;
                $display("FAIL %s reg_rd_data actual=%h expected=%h t=%0t", tag, reg_rd_data, m_reg, $time);
            end
            if (rsp_valid !== m_rv || rsp_retry !== m_rr) begin
                miscompares++;
                $display("FAIL %s rsp valid/retry actual=%b%b expected=%b%b t=%0t",
                         tag, rsp_valid, rsp_retry, m_rv, m_rr, $time);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            miscompares++;
            $display("FAIL watchdog actual=%0d cycles expected<=100000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    function automatic logic [31:0] cmd(input bit trig, input int slot, input int grp, input int val);
        return (32'(val) << 16) | (32'(grp) << 8) | (32'(slot) << 1) | 32'(trig);
    endfunction

    task automatic step(input bit we, input logic [31:0] wd, input bit rv,
                        input int slot, input int func, input bit vf, input int par);
        @(negedge clk);
        reg_wr_en = we; reg_wr_data = wd; req_valid = rv;
        req_slot = 5'(slot); req_func = 5'(func); req_is_vf = vf; req_parent_func = 5'(par);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, 0, 0, 0, 0);
    endtask

    task automatic ask(input int slot, input int func);
        step(0, '0, 1, slot, func, 0, 0);
    endtask

    task automatic update(input int slot, input int grp, input int val);
        step(1, cmd(1, slot, grp, val), 0, 0, 0, 0, 0);
        idle(4);
    endtask

    initial begin
        // R1: reset state
        tag = "R1";
        rst_n = 0; idle(3); rst_n = 1;
        ask(0, 0); ask(0, 0); idle(2);
        // R2 R10: reserved bits dropped, plain write leaves flags alone
        tag = "R2 R10";
        step(1, 32'hFFFF_FFFE, 0, 0, 0, 0, 0); idle(1);
        ask(31, 31); idle(2);
        // R3 R4 R5: trigger an update, request every cycle, write in mid-update
        tag = "R3 R4 R5";
        step(1, cmd(1, 3, 1, 8'hA5), 1, 3, 8, 0, 0);
        step(1, cmd(1, 7, 2, 8'hFF), 1, 3, 8, 0, 0);
        step(1, 32'h0000_0000, 1, 3, 8, 0, 0);
        ask(3, 8); ask(3, 8); ask(3, 8);
        step(1, cmd(0, 7, 2, 8'hFF), 1, 3, 8, 0, 0);
        idle(2);
        // R6 R8: group mapping and sticky after a normal answer
        tag = "R6 R8";
        ask(3, 9); ask(3, 9); ask(3, 10); ask(3, 10); ask(3, 15); ask(3, 7); ask(3, 16);
        update(3, 1, 8'h00); ask(3, 10);
        update(3, 1, 8'hFF); ask(3, 10); ask(3, 8); ask(3, 11); idle(1);
        update(3, 3, 8'h0F);
        ask(3, 24); ask(3, 27); ask(3, 28); ask(3, 8); ask(4, 24); idle(1);
        // R9: virtual functions use the parent's flags
        tag = "R9";
        update(5, 0, 8'h20);
        step(0, '0, 1, 5, 20, 1, 5);
        step(0, '0, 1, 5, 5, 1, 20);
        step(0, '0, 1, 5, 5, 0, 0);
        step(0, '0, 1, 5, 9, 1, 5);
        idle(2);
        // R7: mixed random traffic
        tag = "R7 R4 R6";
        for (int i = 0; i < 3000; i++) begin
            bit we = ($urandom_range(0, 3) == 0);
            step(we, cmd($urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 3),
                         $urandom_range(0, 255)) | ($urandom() & 32'hFF00_FCC0),
                 $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 31),
                 $urandom_range(0, 1), $urandom_range(0, 31));
        end
        idle(4);
        // R1: reset clears everything again
        tag = "R1";
        rst_n = 0; idle(2); rst_n = 1;
        ask(3, 8); idle(2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule